// File: doc/BRIEF.md
# Bidirectional Cascadable Row Scan Shift Driver

This block is the digital core of a row scan driver for a matrix-addressed flat panel. A chain of storage stages moves a scan token one stage per rising edge of the scan clock. A direction select chooses which end accepts serial data. The stage at the opposite end drives a cascade output, which feeds the serial input of the next device. Chained devices can therefore scan any number of rows.

A strobe copies the chain into an output latch, so the row outputs stay steady while the next pattern is shifted in. Two controls condition every row output. An output-enable input forces all rows to their idle level when it is low. A polarity input inverts the rows, for drivers whose power stages expect active-low drive. The idle level follows the polarity setting, so a blanked row reads as "off" under either polarity.

Reset is asynchronous and active-low, and its release is synchronised to the scan clock inside the block. Level shifting and output current drive belong to the analog stages that follow this block and are not part of it.

Top module: `scan_row_driver`

## Requirements
- R1: While rst_n is low, the shift chain and the output latch are cleared to zero without waiting for a clock edge. During that time ser_out is 0 and every row equals pol_inv.
- R2: When dir_rev is 0 (forward), each rising clk edge moves stage i into stage i+1 and loads ser_in into stage 0.
- R3: When dir_rev is 1 (reverse), each rising clk edge moves stage i into stage i-1 and loads ser_in into stage 63.
- R4: ser_out shows stage 63 in forward mode and stage 0 in reverse mode. A single 1 applied at ser_in for one edge appears at ser_out after exactly 64 edges.
- R5: A rising clk edge with strobe high loads the latch with the chain contents as they stood before that edge's shift.
- R6: While strobe is low, the latch keeps its value, whatever shifting takes place.
- R7: When out_en is 0, every bit of rows equals pol_inv, whatever the latch holds.
- R8: When out_en is 1, rows equals the latch XOR pol_inv on every bit. With pol_inv = 0 a latched 1 drives its row high, and with pol_inv = 1 it drives the row low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock; shifting and latching happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ser_in | input | 1 | Serial scan data entering the chain |
| dir_rev | input | 1 | 0 = forward (enter at stage 0), 1 = reverse (enter at stage 63) |
| strobe | input | 1 | High at a clock edge to copy the chain into the output latch |
| out_en | input | 1 | 1 = rows carry latch data; 0 = rows are held idle |
| pol_inv | input | 1 | 1 = rows inverted; also the idle level while blanked |
| rows | output | 64 | Conditioned row outputs |
| ser_out | output | 1 | Cascade output from the far-end stage |

## Verification
Each shift shows in the chain one edge after the data is applied, and ser_out shows a new bit 64 edges after it enters. The latch shows the strobed pattern right after the strobe edge. out_en and pol_inv act on rows in the same cycle without any register. Internal logic leaves reset two edges after rst_n rises. The bench drives every input on the falling edge and samples on the next falling edge, so each result is read half a period after the edge that produced it. Edges are counted exactly for the 63-, 64- and 65-edge cascade cases. The asynchronous clear is checked between edges, with no clock edge in between.

// File: rtl/scan_drv_pkg.sv
package scan_drv_pkg;

  // Number of stages in one device's scan chain.
  parameter int unsigned SCAN_STAGES = 64;

  // Depth of the reset release synchroniser.
  parameter int unsigned RST_SYNC_DEPTH = 2;

  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_REV = 1'b1
  } scan_dir_e;

endpackage

// File: rtl/scan_rst_sync.sv
module scan_rst_sync #(
  parameter int unsigned DEPTH = scan_drv_pkg::RST_SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [DEPTH-1:0] sync_q;
  logic [DEPTH-1:0] sync_d;

  // A 1 enters at the bottom and ripples up; assertion is immediate.
  always_comb begin
    sync_d = {sync_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[DEPTH-1];

endmodule

// File: rtl/scan_shift_chain.sv
module scan_shift_chain
  import scan_drv_pkg::*;
#(
  parameter int unsigned N = SCAN_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_in,
  input  scan_dir_e    dir,
  output logic [N-1:0] chain_q,
  output logic         ser_out
);

  logic [N-1:0] chain_d;

  // Each stage picks its forward or reverse neighbour.
  for (genvar i = 0; i < int'(N); i++) begin : g_stage
    logic fwd_src;
    logic rev_src;
    if (i == 0) begin : g_fwd_head
      assign fwd_src = ser_in;
    end else begin : g_fwd_mid
      assign fwd_src = chain_q[i-1];
    end
    if (i == int'(N) - 1) begin : g_rev_head
      assign rev_src = ser_in;
    end else begin : g_rev_mid
      assign rev_src = chain_q[i+1];
    end
    assign chain_d[i] = (dir == DIR_REV) ? rev_src : fwd_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  // The far end in the selected direction feeds the next device.
  always_comb begin
    ser_out = (dir == DIR_REV) ? chain_q[0] : chain_q[N-1];
  end

  AST_FWD_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (dir == DIR_FWD) |=> (chain_q == {$past(chain_q[N-2:0]), $past(ser_in)})); // R2

  AST_REV_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (dir == DIR_REV) |=> (chain_q == {$past(ser_in), $past(chain_q[N-1:1])})); // R3

  AST_CASCADE_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (dir == DIR_FWD) ##1 (dir == DIR_FWD) |-> (ser_out == $past(chain_q[N-2]))); // R4

  AST_CASCADE_REV: assert property (@(posedge clk) disable iff (!rst_n)
    (dir == DIR_REV) ##1 (dir == DIR_REV) |-> (ser_out == $past(chain_q[1]))); // R4

endmodule

// File: rtl/scan_out_latch.sv
module scan_out_latch #(
  parameter int unsigned N = scan_drv_pkg::SCAN_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [N-1:0] din,
  output logic [N-1:0] lat_q
);

  logic [N-1:0] lat_d;

  // Clock enable written out: hold unless the strobe is high.
  always_comb begin
    lat_d = lat_q;
    if (load_en) begin
      lat_d = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else begin
      lat_q <= lat_d;
    end
  end

  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (lat_q == $past(din))); // R5

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(lat_q)); // R6

endmodule

// File: rtl/scan_out_cond.sv
module scan_out_cond #(
  parameter int unsigned N = scan_drv_pkg::SCAN_STAGES
) (
  input  logic [N-1:0] lat_q,
  input  logic         out_en,
  input  logic         pol_inv,
  output logic [N-1:0] rows
);

  // Per-row conditioning: the idle level equals the polarity bit.
  for (genvar i = 0; i < int'(N); i++) begin : g_row
    assign rows[i] = out_en ? (lat_q[i] ^ pol_inv) : pol_inv;
  end

endmodule

// File: rtl/scan_row_driver.sv
module scan_row_driver
  import scan_drv_pkg::*;
#(
  parameter int unsigned N = SCAN_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_in,
  input  logic         dir_rev,
  input  logic         strobe,
  input  logic         out_en,
  input  logic         pol_inv,
  output logic [N-1:0] rows,
  output logic         ser_out
);

  logic         rst_sync_n;
  logic [N-1:0] chain_q;
  logic [N-1:0] lat_q;
  scan_dir_e    dir;

  assign dir = scan_dir_e'(dir_rev);

  scan_rst_sync #(.DEPTH(RST_SYNC_DEPTH)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  scan_shift_chain #(.N(N)) u_chain (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ser_in  (ser_in),
    .dir     (dir),
    .chain_q (chain_q),
    .ser_out (ser_out)
  );

  scan_out_latch #(.N(N)) u_latch (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_en (strobe),
    .din     (chain_q),
    .lat_q   (lat_q)
  );

  scan_out_cond #(.N(N)) u_cond (
    .lat_q   (lat_q),
    .out_en  (out_en),
    .pol_inv (pol_inv),
    .rows    (rows)
  );

  AST_BLANK_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !out_en |-> (rows == {N{pol_inv}})); // R7

  AST_POLARITY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_en |-> ((rows ^ {N{pol_inv}}) == lat_q)); // R8

endmodule

// File: tb/sim_scan_row_driver.sv
module sim_scan_row_driver;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ser_in, dir_rev, strobe, out_en, pol_inv;
  logic [63:0] rows;
  logic        ser_out;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  scan_row_driver u0 (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .dir_rev(dir_rev),
    .strobe(strobe), .out_en(out_en), .pol_inv(pol_inv),
    .rows(rows), .ser_out(ser_out)
  );

  // Fields: {dir, pol, en, pattern[64], expected rows[64], expected ser_out}
  localparam logic [131:0] VTAB [6] = '{
    {1'b0, 1'b0, 1'b1, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001, 1'b1},
    {1'b1, 1'b0, 1'b1, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001, 1'b1},
    {1'b0, 1'b1, 1'b1, 64'hF0F0_0000_FFFF_1234, 64'h0F0F_FFFF_0000_EDCB, 1'b1},
    {1'b1, 1'b1, 1'b1, 64'h0000_0000_0000_00FE, 64'hFFFF_FFFF_FFFF_FF01, 1'b0},
    {1'b0, 1'b0, 1'b0, 64'hDEAD_BEEF_0BAD_F00D, 64'h0000_0000_0000_0000, 1'b1},
    {1'b1, 1'b1, 1'b0, 64'h5555_AAAA_5555_AAAA, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Fill the chain so that it holds pat after 64 edges.
  task automatic load_pat(input logic dir, input logic [63:0] pat);
    dir_rev = dir;
    for (int t = 0; t < 64; t++) begin
      ser_in = dir ? pat[t] : pat[63-t];
      tick();
    end
    ser_in = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    @(negedge clk);
    rst_n = 1'b1;
    tick(); tick(); tick();
  endtask

  initial begin
    rst_n = 1'b1; ser_in = 1'b0; dir_rev = 1'b0; strobe = 1'b0;
    out_en = 1'b1; pol_inv = 1'b0;
    #2 rst_n = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rows in reset", rows, 64'h0);
    chk("R1 ser_out in reset", {63'h0, ser_out}, 64'h0);
    pol_inv = 1'b1; #1;
    chk("R1 rows in reset pol", rows, {64{1'b1}});
    pol_inv = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    tick(); tick(); tick();

    // Vector table: R2/R3 load, R4 cascade bit, R5 strobe, R7/R8 conditioning
    for (int v = 0; v < 6; v++) begin
      logic [131:0] e;
      e = VTAB[v];
      pol_inv = e[130];
      out_en  = e[129];
      load_pat(e[131], e[128:65]);
      chk(e[131] ? "R4 R3 ser_out rev" : "R4 R2 ser_out fwd", {63'h0, ser_out}, {63'h0, e[0]});
      strobe = 1'b1;
      tick();
      strobe = 1'b0;
      chk("R5 R7 R8 rows", rows, e[64:1]);
    end

    // R6: shifting without strobe leaves the latch untouched
    pol_inv = 1'b0; out_en = 1'b1;
    load_pat(1'b0, 64'h8000_0000_0000_0001);
    strobe = 1'b1; tick(); strobe = 1'b0;
    ser_in = 1'b1;
    for (int k = 0; k < 10; k++) tick();
    ser_in = 1'b0;
    chk("R6 latch hold", rows, 64'h8000_0000_0000_0001);
    out_en = 1'b0; #1;
    chk("R7 blank pol0", rows, 64'h0);
    out_en = 1'b1;

    // R1: asynchronous clear between edges
    rst_n = 1'b0; #1;
    chk("R1 async clear rows", rows, 64'h0);
    chk("R1 async clear ser_out", {63'h0, ser_out}, 64'h0);
    @(negedge clk); rst_n = 1'b1;
    tick(); tick(); tick();

    // R4/R2: single token forward, 64 edges exactly
    dir_rev = 1'b0; ser_in = 1'b1; tick(); ser_in = 1'b0;
    for (int k = 0; k < 62; k++) tick();
    chk("R4 fwd after 63 edges", {63'h0, ser_out}, 64'h0);
    tick();
    chk("R4 fwd after 64 edges", {63'h0, ser_out}, 64'h1);
    tick();
    chk("R4 fwd after 65 edges", {63'h0, ser_out}, 64'h0);

    // R4/R3: single token reverse
    do_reset();
    dir_rev = 1'b1; ser_in = 1'b1; tick(); ser_in = 1'b0;
    for (int k = 0; k < 62; k++) tick();
    chk("R4 R3 rev after 63 edges", {63'h0, ser_out}, 64'h0);
    tick();
    chk("R4 R3 rev after 64 edges", {63'h0, ser_out}, 64'h1);

    // R5: strobe captures pre-shift contents (token at stage 0, not 1)
    do_reset();
    dir_rev = 1'b0; ser_in = 1'b1; tick(); ser_in = 1'b0;
    strobe = 1'b1; tick(); strobe = 1'b0;
    chk("R5 pre-shift capture", rows, 64'h1);
    pol_inv = 1'b1; #1;
    chk("R8 inverted single row", rows, ~64'h1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule